// File: doc/BRIEF.md
# Resettable Programmable Timer Divider

The block turns a stream of master ticks into a slow square wave with equal high and low phases. A fixed power-of-two prescaler feeds a selectable divider with eight ratios, so that the full output period is `2^PRE_LOG2 * 2^(STEP_LOG2*k)` ticks for a ratio step `k` of 0 to 7. With the default parameters this gives periods of 1024 ticks times 1, 8, 64, 512, 4096, 2^15, 2^18 or 2^21. All logic runs on one clock, and `tick` marks the cycles that count as master periods.

A 4-bit configuration code picks the ratio and a polarity bit at once. The upper half of the code space mirrors the lower half, so a ratio can be reached with either polarity. The polarity bit sets the active level of an asynchronous reset pin and decides whether the output is inverted. The reset pin only clears the output latch: the divider keeps counting underneath, so the pin can suppress pulses without moving the output's phase. After power-on the output stays low for a start-up interval and until a code has passed a stability filter. Later code changes are taken up only after the same filter. A halt input freezes the divider and the output.

Top module: `tmr_divider`

## Requirements
- R1: While `por` is high, `clk_out` is 0.
- R2: After `por` falls, `clk_out` stays 0 for the first START_TICKS counted ticks and for as long as no code has been accepted. With polarity 0 the first rise comes at the first divider toggle after both conditions hold.
- R3: The code selects the ratio step k = code[3] ? 15 - code : code. Bit 3 is the polarity. Each output phase lasts H = 2^(PRE_LOG2-1+k*STEP_LOG2) counted ticks, and polarity 1 inverts the output.
- R4: `rst_pin` passes through a two-stage synchronizer. With polarity 0 a high pin forces `clk_out` to 0. With polarity 1 a low pin forces `clk_out` to 1. The forced level shows on the third clock edge after the pin changes.
- R5: The divider keeps counting while the reset is active. Every divider-driven output edge, including the first edge after reset is released, falls on a counted tick whose running total since `por` is a multiple of H.
- R6: With polarity 1, `clk_out` goes to 1 when the output is first enabled. If the reset is inactive it falls again one counted tick later. If the reset is active it stays 1.
- R7: A code is accepted only after FILT_LEN consecutive counted ticks have sampled it unchanged. A code held for fewer ticks has no effect on the output.
- R8: An accepted ratio applies at once. No output phase is shorter than one counted tick, and every phase after the first edge under the new ratio lasts the new H.
- R9: While `halt` is high, `clk_out` and the divider hold their state, and ticks in those cycles are not counted.
- R10: When the reset takes effect in the same cycle as a divider toggle, the reset wins and the output stays at the forced level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock |
| por | input | 1 | Synchronous active-high power-on reset |
| tick | input | 1 | Master-period enable |
| halt | input | 1 | Freezes the divider and the output |
| cfg_code | input | 4 | Ratio step and polarity code |
| rst_pin | input | 1 | Asynchronous output reset, sense set by polarity |
| clk_out | output | 1 | Divided output clock |

## Verification
The reset reaching the output latch and a divider toggle can fall on the same clock edge. The bench provokes this by raising the reset pin one tick after a falling output edge, so that the synchronizer delivers it exactly on the tick that would raise the output again. The output must stay low on that edge, and the next rise after release must land on a tick count that is a multiple of the half period. Code acceptance and a toggle can also coincide: random tick gaps and random codes move the acceptance point around, and every phase after the first edge under the new ratio must equal the new half period.

// File: rtl/tmr_div_pkg.sv
package tmr_div_pkg;

   localparam int NUM_RATIOS = 8;
   localparam int STEP_W     = 3;

   typedef logic [3:0]        cfg_t;
   typedef logic [STEP_W-1:0] step_t;

   // mirrored mapping: the upper half of the code space counts down
   function automatic step_t ratio_step(input cfg_t c);
      logic [3:0] m;
      m = c[3] ? (4'd15 - c) : c;
      return m[STEP_W-1:0];
   endfunction

   function automatic logic polarity_of(input cfg_t c);
      return c[3];
   endfunction

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic por,
   input  logic d,
   output logic q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("tmr_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic s;
      always_ff @(posedge clk) begin
         if (por) s <= 1'b0;
         else     s <= d;
      end
      assign q = s;
   end else begin : g_chain
      logic [STAGES-1:0] s;
      always_ff @(posedge clk) begin
         if (por) s <= '0;
         else     s <= {s[STAGES-2:0], d};
      end
      assign q = s[STAGES-1];
   end
endmodule

// File: rtl/tmr_code_filter.sv
module tmr_code_filter
   import tmr_div_pkg::*;
#(
   parameter int FILT_LEN = 16
) (
   input  logic clk,
   input  logic por,
   input  logic step,
   input  cfg_t code,
   output cfg_t act_code,
   output logic valid
);
   localparam int RUN_W = $clog2(FILT_LEN + 1);

   if (FILT_LEN < 2) begin : g_bad_len
      $error("tmr_code_filter: FILT_LEN must be at least 2");
   end

   cfg_t             cand;
   logic [RUN_W-1:0] run;

   always_ff @(posedge clk) begin
      if (por) begin
         cand     <= '0;
         run      <= '0;
         act_code <= '0;
         valid    <= 1'b0;
      end else if (step) begin
         if (code != cand) begin
            cand <= code;
            run  <= RUN_W'(1);
         end else if (run == RUN_W'(FILT_LEN - 1)) begin
            act_code <= cand;
            valid    <= 1'b1;
         end else begin
            run <= run + RUN_W'(1);
         end
      end
   end
endmodule

// File: rtl/tmr_startup.sv
module tmr_startup #(
   parameter int START_TICKS = 500
) (
   input  logic clk,
   input  logic por,
   input  logic step,
   output logic done
);
   localparam int SC_W = $clog2(START_TICKS + 1);

   if (START_TICKS < 1) begin : g_bad_start
      $error("tmr_startup: START_TICKS must be at least 1");
   end

   logic [SC_W-1:0] sc;

   always_ff @(posedge clk) begin
      if (por) begin
         sc   <= '0;
         done <= 1'b0;
      end else if (step && !done) begin
         sc <= sc + SC_W'(1);
         if (sc == SC_W'(START_TICKS - 1)) done <= 1'b1;
      end
   end
endmodule

// File: rtl/tmr_ratio_counter.sv
module tmr_ratio_counter
   import tmr_div_pkg::*;
#(
   parameter int PRE_LOG2  = 10,
   parameter int STEP_LOG2 = 3,
   localparam int CNT_W    = PRE_LOG2 + (NUM_RATIOS - 1) * STEP_LOG2
) (
   input  logic             clk,
   input  logic             por,
   input  logic             step,
   input  step_t            sel,
   output logic             toggle,
   output logic [CNT_W-1:0] cnt_o
);
   if (PRE_LOG2 < 2) begin : g_bad_pre
      $error("tmr_ratio_counter: PRE_LOG2 must be at least 2");
   end
   if (STEP_LOG2 < 1) begin : g_bad_step
      $error("tmr_ratio_counter: STEP_LOG2 must be at least 1");
   end

   logic [CNT_W-1:0]      cnt;
   logic [NUM_RATIOS-1:0] wrap;

   always_ff @(posedge clk) begin
      if (por)       cnt <= '0;
      else if (step) cnt <= cnt + CNT_W'(1);
   end

   // one half-period wrap detector per ratio step
   for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_wrap
      localparam int K = PRE_LOG2 - 1 + i * STEP_LOG2;
      assign wrap[i] = &cnt[K-1:0];
   end

   assign toggle = step & wrap[sel];
   assign cnt_o  = cnt;
endmodule

// File: rtl/tmr_out_latch.sv
module tmr_out_latch (
   input  logic clk,
   input  logic por,
   input  logic step,
   input  logic halt,
   input  logic en,
   input  logic pol,
   input  logic rst_act,
   input  logic toggle,
   output logic out
);
   logic q;
   logic armed;

   always_ff @(posedge clk) begin
      if (por) begin
         q     <= 1'b0;
         armed <= 1'b1;
      end else if (!halt) begin
         if (!en) begin
            q     <= 1'b0;
            armed <= 1'b1;
         end else begin
            if (step) armed <= 1'b0;
            // reset outranks the start-up kick, which outranks a toggle
            if (rst_act)                  q <= 1'b0;
            else if (armed && step && pol) q <= 1'b1;
            else if (toggle)              q <= ~q;
         end
      end
   end

   assign out = en & (q ^ pol);
endmodule

// File: rtl/tmr_divider.sv
module tmr_divider
   import tmr_div_pkg::*;
#(
   parameter int PRE_LOG2    = 10,
   parameter int STEP_LOG2   = 3,
   parameter int START_TICKS = 500,
   parameter int FILT_LEN    = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       por,
   input  logic       tick,
   input  logic       halt,
   input  logic [3:0] cfg_code,
   input  logic       rst_pin,
   output logic       clk_out
);
   localparam int CNT_W = PRE_LOG2 + (NUM_RATIOS - 1) * STEP_LOG2;

   if (FILT_LEN > 500) begin : g_bad_filter
      $error("tmr_divider: FILT_LEN must not exceed 500 ticks");
   end

   logic             step;
   logic             pin_s;
   logic             rst_act;
   logic             pol;
   logic             code_ok;
   logic             st_done;
   logic             out_en;
   logic             toggle;
   cfg_t             act_code;
   step_t            sel;
   logic [CNT_W-1:0] div_cnt;

   assign step = tick & ~halt;

   tmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .por (por),
      .d   (rst_pin),
      .q   (pin_s)
   );

   tmr_code_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk      (clk),
      .por      (por),
      .step     (step),
      .code     (cfg_code),
      .act_code (act_code),
      .valid    (code_ok)
   );

   tmr_startup #(.START_TICKS(START_TICKS)) u_start (
      .clk  (clk),
      .por  (por),
      .step (step),
      .done (st_done)
   );

   assign sel     = ratio_step(act_code);
   assign pol     = polarity_of(act_code);
   assign rst_act = pol ? ~pin_s : pin_s;
   assign out_en  = st_done & code_ok;

   tmr_ratio_counter #(
      .PRE_LOG2  (PRE_LOG2),
      .STEP_LOG2 (STEP_LOG2)
   ) u_cnt (
      .clk    (clk),
      .por    (por),
      .step   (step),
      .sel    (sel),
      .toggle (toggle),
      .cnt_o  (div_cnt)
   );

   tmr_out_latch u_latch (
      .clk     (clk),
      .por     (por),
      .step    (step),
      .halt    (halt),
      .en      (out_en),
      .pol     (pol),
      .rst_act (rst_act),
      .toggle  (toggle),
      .out     (clk_out)
   );
endmodule

// File: rtl/tmr_divider_chk.sv
module tmr_divider_chk #(
   parameter int START_TICKS = 500,
   parameter int CNT_W       = 31
) (
   input logic             clk,
   input logic             por,
   input logic             tick,
   input logic             halt,
   input logic [3:0]       cfg_code,
   input logic             clk_out,
   input logic             en,
   input logic             pol,
   input logic             rst_act,
   input logic [3:0]       act_code,
   input logic [CNT_W-1:0] div_cnt
);
   logic [31:0] seen;

   always_ff @(posedge clk) begin
      if (por) seen <= '0;
      else if (tick && !halt && seen < 32'(START_TICKS)) seen <= seen + 32'd1;
   end

   AST_START_HOLD: assert property (@(posedge clk) disable iff (por)
      (seen < 32'(START_TICKS)) |-> !clk_out);                        // R2

   AST_RESET_FORCE: assert property (@(posedge clk) disable iff (por)
      (rst_act && en && !halt) |=> (clk_out == pol));                 // R4

   AST_EDGE_ON_TICK: assert property (@(posedge clk) disable iff (por)
      (!$past(tick) && !$past(rst_act)) |-> $stable(clk_out));        // R8

   AST_FILTER_SRC: assert property (@(posedge clk) disable iff (por)
      !$stable(act_code) |-> ($past(cfg_code) == act_code));          // R7

   AST_HALT_OUT: assert property (@(posedge clk) disable iff (por)
      halt |=> $stable(clk_out));                                     // R9

   AST_HALT_DIV: assert property (@(posedge clk) disable iff (por)
      halt |=> $stable(div_cnt));                                     // R9
endmodule

bind tmr_divider tmr_divider_chk #(
   .START_TICKS (START_TICKS),
   .CNT_W       (CNT_W)
) u_chk (
   .clk      (clk),
   .por      (por),
   .tick     (tick),
   .halt     (halt),
   .cfg_code (cfg_code),
   .clk_out  (clk_out),
   .en       (out_en),
   .pol      (pol),
   .rst_act  (rst_act),
   .act_code (act_code),
   .div_cnt  (div_cnt)
);

// File: tb/tmr_divider_bench.sv
`timescale 1ns/1ps
module tmr_divider_bench;
   localparam int PRE  = 3;
   localparam int STP  = 1;
   localparam int STTK = 20;
   localparam int FLT  = 4;

   logic       clk = 1'b0;
   logic       por = 1'b1;
   logic       tick = 1'b1;
   logic       halt = 1'b0;
   logic [3:0] cfg_code = 4'd0;
   logic       rst_pin = 1'b0;
   logic       clk_out;

   int  n_chk = 0, n_bad = 0;
   int  T = 0, ph = 0, last_ph = 0;
   bit  edge_seen = 0;
   logic last_out = 1'b0;

   always #10 clk = ~clk;

   tmr_divider #(
      .PRE_LOG2(PRE), .STEP_LOG2(STP), .START_TICKS(STTK),
      .FILT_LEN(FLT), .SYNC_STAGES(2)
   ) u_tmr_divider (
      .clk(clk), .por(por), .tick(tick), .halt(halt),
      .cfg_code(cfg_code), .rst_pin(rst_pin), .clk_out(clk_out)
   );

   function automatic int half_of(input logic [3:0] c);
      int k;
      k = c[3] ? 15 - int'(c) : int'(c);
      return 1 << (PRE - 1 + k * STP);
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic cyc();
      bit e;
      e = tick && !halt && !por;
      @(negedge clk);
      edge_seen = 0;
      if (e) begin T++; ph++; end
      if (clk_out !== last_out) begin
         edge_seen = 1; last_ph = ph; ph = 0; last_out = clk_out;
      end
   endtask

   task automatic wait_edge(input int maxc, input bit rnd, output bit got);
      got = 0;
      for (int i = 0; i < maxc; i++) begin
         if (rnd) tick = ($urandom % 4) != 0;
         cyc();
         if (edge_seen) begin got = 1; break; end
      end
   endtask

   task automatic wait_ticks(input int n, input bit rnd);
      int t0;
      t0 = T;
      while (T < t0 + n) begin
         if (rnd) tick = ($urandom % 4) != 0;
         cyc();
      end
   endtask

   task automatic do_por(input logic [3:0] c, input logic p);
      por = 1'b1; tick = 1'b1; halt = 1'b0; cfg_code = c; rst_pin = p;
      repeat (4) cyc();
      T = 0; ph = 0; last_out = clk_out;
      por = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      bit g;
      int bad;
      logic v;
      logic [3:0] c;
      void'($urandom(32'd7301));

      // ---- R1: reset state
      do_por(4'd0, 1'b0);
      check(clk_out === 1'b0, "R1", "out during por", int'(clk_out), 0);

      // ---- R2: first rise at first toggle after start-up
      wait_edge(200, 0, g);
      check(g && clk_out === 1'b1 && T == 24, "R2", "first rise tick", T, 24);
      // ---- R3: phase length for code 0
      for (int i = 0; i < 3; i++) begin
         wait_edge(200, 0, g);
         check(g && last_ph == 4 && T % 4 == 0, "R3", "code0 phase", last_ph, 4);
      end

      // ---- R10 / R4 / R5 with polarity 0
      do begin wait_edge(200, 0, g); end while (clk_out !== 1'b0);
      cyc();
      rst_pin = 1'b1;
      repeat (3) cyc();
      check(clk_out === 1'b0 && T % 4 == 0, "R10", "reset beats toggle", int'(clk_out), 0);
      bad = 0;
      repeat (20) begin cyc(); if (clk_out !== 1'b0) bad++; end
      check(bad == 0, "R4", "pol0 forced low cycles", bad, 0);
      rst_pin = 1'b0;
      wait_edge(200, 0, g);
      check(g && clk_out === 1'b1 && T % 4 == 0, "R5", "rise aligned after release", T % 4, 0);

      // ---- R7: short code pulse ignored
      cfg_code = 4'd2;
      repeat (FLT - 1) cyc();
      cfg_code = 4'd0;
      wait_edge(200, 0, g);
      wait_edge(200, 0, g);
      check(g && last_ph == 4, "R7", "phase after short pulse", last_ph, 4);

      // ---- R8: ratio change
      cfg_code = 4'd2;
      wait_ticks(FLT + 1, 0);
      wait_edge(400, 0, g);
      check(g && last_ph >= 1, "R8", "first phase after change", last_ph, 1);
      for (int i = 0; i < 2; i++) begin
         wait_edge(400, 0, g);
         check(g && last_ph == 16 && T % 16 == 0, "R8", "new phase", last_ph, 16);
      end

      // ---- R9: halt
      v = clk_out;
      halt = 1'b1;
      bad = 0;
      repeat (30) begin cyc(); if (clk_out !== v) bad++; end
      check(bad == 0, "R9", "changes during halt", bad, 0);
      halt = 1'b0;
      wait_edge(400, 0, g);
      check(g && T % 16 == 0, "R9", "edge aligned after halt", T % 16, 0);

      // ---- R3 mirror code with polarity 1, R4 / R5
      cfg_code = 4'd13;
      rst_pin = 1'b1;
      wait_ticks(FLT + 1, 0);
      wait_edge(400, 0, g);
      for (int i = 0; i < 2; i++) begin
         wait_edge(400, 0, g);
         check(g && last_ph == 16 && T % 16 == 0, "R3", "mirror phase", last_ph, 16);
      end
      rst_pin = 1'b0;
      repeat (3) cyc();
      check(clk_out === 1'b1, "R4", "pol1 forced high", int'(clk_out), 1);
      bad = 0;
      repeat (20) begin cyc(); if (clk_out !== 1'b1) bad++; end
      check(bad == 0, "R4", "pol1 forced high cycles", bad, 0);
      rst_pin = 1'b1;
      wait_edge(400, 0, g);
      check(g && clk_out === 1'b0 && T % 16 == 0, "R5", "pol1 fall after release", T % 16, 0);

      // ---- R6: polarity 1 start-up, reset inactive
      do_por(4'd15, 1'b1);
      wait_edge(200, 0, g);
      check(g && clk_out === 1'b1 && T == STTK, "R6", "enable rise tick", T, STTK);
      wait_edge(200, 0, g);
      check(g && clk_out === 1'b0 && last_ph == 1, "R6", "kick fall phase", last_ph, 1);
      wait_edge(200, 0, g);
      check(g && T == 24, "R6", "first toggle tick", T, 24);

      // ---- R6: polarity 1 start-up, reset active
      do_por(4'd15, 1'b0);
      wait_edge(200, 0, g);
      check(g && clk_out === 1'b1 && T == STTK, "R6", "enable rise under reset", T, STTK);
      wait_edge(80, 0, g);
      check(!g && clk_out === 1'b1, "R6", "held high under reset", int'(clk_out), 1);

      // ---- R2: no accepted code keeps output low
      do_por(4'd0, 1'b0);
      bad = 0;
      for (int i = 0; i < 40; i++) begin
         cfg_code = 4'(i % 2);
         cyc();
         if (clk_out !== 1'b0) bad++;
      end
      check(bad == 0, "R2", "low without accepted code", bad, 0);
      cfg_code = 4'd0;
      wait_edge(200, 0, g);
      check(g && clk_out === 1'b1 && T % 4 == 0, "R2", "rise after acceptance", T % 4, 0);

      // ---- R3 / R8: random codes and tick gaps
      for (int s = 0; s < 8; s++) begin
         c = 4'($urandom % 16);
         cfg_code = c;
         rst_pin = c[3];
         wait_ticks(FLT + 1, 1);
         wait_edge(4000, 1, g);
         for (int i = 0; i < 2; i++) begin
            wait_edge(4000, 1, g);
            check(g && last_ph == half_of(c) && T % half_of(c) == 0,
                  "R8", "random segment phase", last_ph, half_of(c));
         end
      end
      tick = 1'b1;

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule